// File: doc/BRIEF.md
# Dual-Button Long-Press Reset Generator

This block turns a deliberate two-button hold into a hard reset. Two active-low push-button lines are watched together. A setup timer runs only while both lines are low at the same moment. If either line returns high, the press is abandoned and the count starts over. A short closure gives no reset, so the same buttons can also serve as an ordinary interrupt source.

The setup time is picked by a two-bit select that stands in for a three-level pin. The choices are 2 s, 6 s or 10 s. When the count completes, two reset outputs assert on the same clock edge. One output is active-high. The other is active-low, which models an open-drain line that is pulled low while asserted. Each output then releases after its own pulse length. An undervoltage flag from an external comparator forces both outputs active for as long as it stays high. After the flag clears, each output again holds for its own pulse length.

All durations are given in milliseconds and converted to clock ticks through a ticks-per-millisecond parameter. A simulation can therefore shrink every time by the same factor.

Top module: `lp_reset_gen`

## Requirements
- R1: The setup count advances only while both synchronized button lines are low. A single sampled high level on either line clears the count. Holding only one button never produces a reset.
- R2: The select `dly_sel_i` encodes the setup time L = ms x TICKS_PER_MS: 2'b00 gives 2000 ms, 2'b01 gives 6000 ms, 2'b10 gives 10000 ms, and 2'b11 is treated as 6000 ms. If the buttons are first sampled low at clock edge n+1 and stay low through edge n+L, the outputs assert at edge n+L+2.
- R3: A simultaneous closure that is sampled low on only L-1 consecutive edges produces no change on either output.
- R4: Both outputs assert on the same edge. `rst_hi_o` goes to 1 and `rst_lo_no` goes to 0.
- R5: `rst_hi_o` stays high for exactly PULSE_A_MS x TICKS_PER_MS cycles after it asserts.
- R6: `rst_lo_no` stays low for PULSE_B_MS x TICKS_PER_MS cycles (210 ms) when `long_pulse_i` is 0. It stays low for PULSE_B_ALT_MS x TICKS_PER_MS cycles (360 ms) when `long_pulse_i` is 1.
- R7: A continuous hold produces only one reset pulse. Both buttons must be seen high again before another press can be counted.
- R8: When `uv_i` is sampled high at an edge, both outputs are active after that edge. They stay active for as long as `uv_i` remains high.
- R9: Take the last edge at which `uv_i` is sampled high. Each output releases its own pulse length after that edge. This holds even when a button-started pulse was already running, because its release timer restarts.
- R10: While `rst_ni` is low, `rst_hi_o` is 0 and `rst_lo_no` is 1, and all timers are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| btn_a_ni | input | 1 | First push-button line, active low |
| btn_b_ni | input | 1 | Second push-button line, active low |
| dly_sel_i | input | 2 | Setup time select (00: 2 s, 01/11: 6 s, 10: 10 s) |
| long_pulse_i | input | 1 | Selects the longer pulse for the active-low output |
| uv_i | input | 1 | Undervoltage flag, active high |
| rst_hi_o | output | 1 | Active-high reset output |
| rst_lo_no | output | 1 | Active-low reset output |

## Verification
Take a button press that is first sampled at edge n+1. Two synchronizer stages and the setup count place its assertion at edge n+L+2. Each release follows exactly its pulse length in cycles after the assertion. For an undervoltage event, assertion follows the first edge that samples the flag high, and release counts from the last edge that samples it high. The driver changes inputs on falling edges and puts each predicted output change, stamped with its exact edge number, into a queue. The monitor detects every output change on a falling edge and compares it with the head of the queue, so any early, late, missing or extra change is caught.

// File: rtl/lp_reset_pkg.sv
package lp_reset_pkg;

  typedef enum logic [1:0] {
    DLY_SHORT = 2'b00,
    DLY_MID   = 2'b01,
    DLY_LONG  = 2'b10,
    DLY_ALT   = 2'b11
  } dly_sel_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lp_sync.sv
module lp_sync #(
  parameter int          WIDTH     = 2,
  parameter int          STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [WIDTH-1:0] d_stage;
    if (g == 0) begin : g_first
      assign d_stage = d_i;
    end else begin : g_next
      assign d_stage = stage_q[g-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[g] <= {WIDTH{RESET_VAL}};
      else         stage_q[g] <= d_stage;
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/lp_press_timer.sv
module lp_press_timer #(
  parameter int CW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          both_low_i,
  input  logic [CW-1:0] limit_i,
  output logic          fire_o
);

  logic [CW-1:0] cnt_q;
  logic          armed_q;
  logic          at_end;

  assign at_end = (cnt_q == limit_i - CW'(1));
  assign fire_o = both_low_i & armed_q & at_end;

  // armed_q clears on fire and returns only after a release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else if (!both_low_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else if (armed_q) begin
      if (at_end) begin
        cnt_q   <= '0;
        armed_q <= 1'b0;
      end else begin
        cnt_q   <= cnt_q + CW'(1);
      end
    end
  end

endmodule

// File: rtl/lp_pulse_timer.sv
module lp_pulse_timer #(
  parameter int CW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fire_i,
  input  logic          hold_i,
  input  logic [CW-1:0] limit_i,
  output logic          active_o
);

  logic [CW-1:0] cnt_q;
  logic          active_q;

  // hold or fire restarts the release count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (hold_i || fire_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (active_q) begin
      if (cnt_q == limit_i - CW'(1)) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q    <= cnt_q + CW'(1);
      end
    end
  end

  assign active_o = active_q;

endmodule

// File: rtl/lp_reset_gen.sv
module lp_reset_gen
  import lp_reset_pkg::*;
#(
  parameter int TICKS_PER_MS   = 1000,
  parameter int SETUP_SHORT_MS = 2000,
  parameter int SETUP_MID_MS   = 6000,
  parameter int SETUP_LONG_MS  = 10000,
  parameter int PULSE_A_MS     = 100,
  parameter int PULSE_B_MS     = 210,
  parameter int PULSE_B_ALT_MS = 360,
  parameter int SYNC_STAGES    = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       btn_a_ni,
  input  logic       btn_b_ni,
  input  logic [1:0] dly_sel_i,
  input  logic       long_pulse_i,
  input  logic       uv_i,
  output logic       rst_hi_o,
  output logic       rst_lo_no
);

  localparam int T_SS   = SETUP_SHORT_MS * TICKS_PER_MS;
  localparam int T_SM   = SETUP_MID_MS   * TICKS_PER_MS;
  localparam int T_SL   = SETUP_LONG_MS  * TICKS_PER_MS;
  localparam int T_PA   = PULSE_A_MS     * TICKS_PER_MS;
  localparam int T_PB   = PULSE_B_MS     * TICKS_PER_MS;
  localparam int T_PBA  = PULSE_B_ALT_MS * TICKS_PER_MS;
  localparam int MAX_T  = max_of(max_of(max_of(T_SS, T_SM), max_of(T_SL, T_PA)),
                                 max_of(T_PB, T_PBA));
  localparam int CW     = $clog2(MAX_T + 1);
  localparam int NPULSE = 2;

  logic [1:0]    btn_sync;
  logic          both_low;
  logic          fire;
  logic [CW-1:0] setup_lim;
  logic [CW-1:0] pulse_lim [NPULSE];
  logic [NPULSE-1:0] pulse_act;

  lp_sync #(
    .WIDTH    (2),
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(1'b1)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({btn_b_ni, btn_a_ni}),
    .q_o   (btn_sync)
  );

  assign both_low = (btn_sync == 2'b00);

  always_comb begin
    unique case (dly_sel_e'(dly_sel_i))
      DLY_SHORT: setup_lim = CW'(T_SS);
      DLY_LONG:  setup_lim = CW'(T_SL);
      default:   setup_lim = CW'(T_SM);
    endcase
  end

  lp_press_timer #(.CW(CW)) u_press (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .both_low_i(both_low),
    .limit_i   (setup_lim),
    .fire_o    (fire)
  );

  assign pulse_lim[0] = CW'(T_PA);
  assign pulse_lim[1] = long_pulse_i ? CW'(T_PBA) : CW'(T_PB);

  for (genvar g = 0; g < NPULSE; g++) begin : g_pulse
    lp_pulse_timer #(.CW(CW)) u_pulse (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .fire_i  (fire),
      .hold_i  (uv_i),
      .limit_i (pulse_lim[g]),
      .active_o(pulse_act[g])
    );
  end

  assign rst_hi_o  = pulse_act[0];
  assign rst_lo_no = ~pulse_act[1];

endmodule

// File: rtl/lp_reset_chk.sv
module lp_reset_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic uv_i,
  input logic both_low,
  input logic fire,
  input logic rst_hi_o,
  input logic rst_lo_no
);

  // R4
  hi_rise_lo_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_hi_o) |-> !rst_lo_no);

  // R4
  lo_fall_hi_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_lo_no) |-> rst_hi_o);

  // R4
  fire_asserts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> (rst_hi_o && !rst_lo_no));

  // R1
  fire_needs_both_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |-> both_low);

  // R1
  rise_has_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_hi_o) |-> ($past(fire) || $past(uv_i)));

  // R8
  uv_forces_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_i |=> (rst_hi_o && !rst_lo_no));

  // R9
  hi_release_no_uv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_hi_o) |-> !$past(uv_i));

  // R9
  lo_release_no_uv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_lo_no) |-> !$past(uv_i));

endmodule

bind lp_reset_gen lp_reset_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .uv_i     (uv_i),
  .both_low (both_low),
  .fire     (fire),
  .rst_hi_o (rst_hi_o),
  .rst_lo_no(rst_lo_no)
);

// File: tb/tb_lp_reset_gen.sv
module tb_lp_reset_gen;

  localparam int CLK_PERIOD = 10;
  localparam int TPM        = 1;
  localparam int PA         = 50;
  localparam int PB         = 210;
  localparam int PB_ALT     = 360;
  localparam int L_SHORT    = 2000;
  localparam int L_MID      = 6000;
  localparam int L_LONG     = 10000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       btn_a = 1'b1;
  logic       btn_b = 1'b1;
  logic [1:0] dly_sel = 2'b00;
  logic       long_pulse = 1'b0;
  logic       uv = 1'b0;
  logic       rst_hi_o;
  logic       rst_lo_no;

  int  cyc = 0;
  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  typedef struct {
    int    cyc;
    logic  hi;
    logic  lo_n;
    string tag;
  } exp_t;

  exp_t q[$];
  exp_t e;
  logic prev_hi = 1'b0;
  logic prev_lo = 1'b1;

  lp_reset_gen #(
    .TICKS_PER_MS  (TPM),
    .SETUP_SHORT_MS(L_SHORT),
    .SETUP_MID_MS  (L_MID),
    .SETUP_LONG_MS (L_LONG),
    .PULSE_A_MS    (PA),
    .PULSE_B_MS    (PB),
    .PULSE_B_ALT_MS(PB_ALT),
    .SYNC_STAGES   (2)
  ) dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .btn_a_ni    (btn_a),
    .btn_b_ni    (btn_b),
    .dly_sel_i   (dly_sel),
    .long_pulse_i(long_pulse),
    .uv_i        (uv),
    .rst_hi_o    (rst_hi_o),
    .rst_lo_no   (rst_lo_no)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string msg);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  task automatic push(input int c, input logic hi, input logic lo_n, input string tag);
    exp_t x;
    x.cyc = c; x.hi = hi; x.lo_n = lo_n; x.tag = tag;
    q.push_back(x);
  endtask

  // predicted assertion at F, then each release after its own length
  task automatic push_pulse(input int f, input int pb, input string tag);
    push(f, 1'b1, 1'b0, tag);
    push(f + PA, 1'b0, 1'b0, "R5");
    push(f + pb, 1'b0, 1'b1, "R6");
  endtask

  // monitor: every output change must match the queue head
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rst_hi_o !== prev_hi || rst_lo_no !== prev_lo) begin
        if (q.size() == 0) begin
          check(1'b0, "R3", $sformatf("unexpected change at %0d: hi=%b lo_n=%b, expected none",
                                      cyc, rst_hi_o, rst_lo_no));
        end else begin
          e = q.pop_front();
          check(cyc == e.cyc && rst_hi_o === e.hi && rst_lo_no === e.lo_n, e.tag,
                $sformatf("actual cyc=%0d hi=%b lo_n=%b, expected cyc=%0d hi=%b lo_n=%b",
                          cyc, rst_hi_o, rst_lo_no, e.cyc, e.hi, e.lo_n));
        end
        prev_hi = rst_hi_o;
        prev_lo = rst_lo_no;
      end
    end
  end

  task automatic press(input logic [1:0] sel, input int hold, input int lim, input int pb,
                       input string tag);
    int n;
    @(negedge clk);
    dly_sel = sel;
    n = cyc;
    btn_a = 1'b0;
    btn_b = 1'b0;
    if (lim > 0) push_pulse(n + lim + 2, pb, tag);
    repeat (hold) @(negedge clk);
    btn_a = 1'b1;
    btn_b = 1'b1;
  endtask

  task automatic settle(input int n, input string tag);
    repeat (n) @(negedge clk);
    check(q.size() == 0 && rst_hi_o === 1'b0 && rst_lo_no === 1'b1, tag,
          $sformatf("pending=%0d hi=%b lo_n=%b, expected pending=0 hi=0 lo_n=1",
                    q.size(), rst_hi_o, rst_lo_no));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    int m;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(rst_hi_o === 1'b0 && rst_lo_no === 1'b1, "R10",
          $sformatf("hi=%b lo_n=%b, expected hi=0 lo_n=1", rst_hi_o, rst_lo_no));
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R3: one cycle short of 2 s
    press(2'b00, L_SHORT - 1, 0, PB, "R3");
    settle(50, "R3");
    // R2 R4 R5 R6: exact 2 s hold
    press(2'b00, L_SHORT, L_SHORT, PB, "R2");
    settle(500, "R2");
    // R7: continuous hold at 6 s gives one pulse
    press(2'b01, L_MID + 4000, L_MID, PB, "R7");
    settle(500, "R7");
    // R2: 2'b11 acts as 6 s, not 2 s
    press(2'b11, L_MID - 1, 0, PB, "R2");
    settle(50, "R2");
    press(2'b11, L_MID, L_MID, PB, "R2");
    settle(500, "R2");
    // R2 R6: 10 s with long pulse option
    long_pulse = 1'b1;
    press(2'b10, L_LONG, L_LONG, PB_ALT, "R2");
    settle(500, "R6");
    long_pulse = 1'b0;

    // R1: only one button held
    @(negedge clk);
    dly_sel = 2'b00;
    btn_a = 1'b0;
    repeat (L_SHORT + 500) @(negedge clk);
    btn_a = 1'b1;
    settle(50, "R1");
    // R1: one-cycle bounce on one line clears the count
    @(negedge clk);
    btn_a = 1'b0;
    btn_b = 1'b0;
    repeat (1500) @(negedge clk);
    btn_b = 1'b1;
    @(negedge clk);
    btn_b = 1'b0;
    repeat (1500) @(negedge clk);
    btn_a = 1'b1;
    btn_b = 1'b1;
    settle(50, "R1");

    // R8 R9: undervoltage alone
    @(negedge clk);
    n = cyc;
    uv = 1'b1;
    push(n + 1, 1'b1, 1'b0, "R8");
    repeat (100) @(negedge clk);
    m = cyc;
    uv = 1'b0;
    push(m + PA, 1'b0, 1'b0, "R9");
    push(m + PB, 1'b0, 1'b1, "R9");
    settle(400, "R9");

    // R9: undervoltage during a button pulse restarts both releases
    @(negedge clk);
    dly_sel = 2'b00;
    n = cyc;
    btn_a = 1'b0;
    btn_b = 1'b0;
    push(n + L_SHORT + 2, 1'b1, 1'b0, "R4");
    repeat (L_SHORT + 2 + 20) @(negedge clk);
    uv = 1'b1;
    repeat (30) @(negedge clk);
    m = cyc;
    uv = 1'b0;
    push(m + PA, 1'b0, 1'b0, "R9");
    push(m + PB, 1'b0, 1'b1, "R9");
    repeat (10) @(negedge clk);
    btn_a = 1'b1;
    btn_b = 1'b1;
    settle(400, "R9");

    // R10: reset mid-pulse returns outputs idle
    press(2'b00, L_SHORT, L_SHORT, PB, "R4");
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    q.delete();
    @(negedge clk);
    check(rst_hi_o === 1'b0 && rst_lo_no === 1'b1, "R10",
          $sformatf("hi=%b lo_n=%b, expected hi=0 lo_n=1", rst_hi_o, rst_lo_no));
    prev_hi = 1'b0;
    prev_lo = 1'b1;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule